// File: doc/BRIEF.md
# Boot-select and remap address decoder

This block turns a 32-bit system address and an access size into one region select for a small microcontroller memory map. The select is one of: internal fast SRAM, extended SRAM, external chip select 0, the rest of the external space, or peripherals. With the select it gives the offset inside the selected region, the byte-lane enables for a 32-bit little-endian bus, and an abort flag. The decode is combinational. Its only state is a boot-memory choice and a remap flag.

While the active-low reset is held, the block follows a boot-select pin. It keeps the level seen at the last clock edge before reset is released. Until software issues a remap strobe, the 1 MB zero window aliases the boot memory. A boot value of 1 aliases the extended SRAM and a boot value of 0 aliases the external memory on chip select 0. After the strobe, the zero window aliases the 8 KB internal SRAM, so the exception vectors can be rewritten. The flag stays set until the next reset. Misaligned accesses and holes in the internal region are rejected with the abort flag.

Top module: `boot_remap_decoder`

## Requirements
- R1: The upper regions decode as follows:
  - 0xFFC0_0000 and above selects peripherals, with offset = address − 0xFFC0_0000.
  - 0x0040_0000–0x005F_FFFF selects chip select 0, with offset = address − 0x0040_0000.
  - 0x0060_0000–0xFFBF_FFFF selects other external space, with offset = address − 0x0060_0000.
- R2: 0x0010_0000–0x0011_FFFF always selects the extended SRAM, with offset = address − 0x0010_0000, whatever the boot value and remap state.
- R3: 0x0030_0000–0x0030_1FFF always selects the internal SRAM, with offset = address − 0x0030_0000.
- R4: The boot value is the boot pin level at the last rising clock edge at which rst_n is low. Pin changes after reset release have no effect until the next reset.
- R5: Before remap, an address in 0x0000_0000–0x000F_FFFF decodes as follows:
  - With boot value 1, it selects the extended SRAM with offset = address mod 0x2_0000.
  - With boot value 0, it selects chip select 0 with offset = address mod 0x20_0000.
- R6: If remap_i is high at a rising edge with rst_n high, the zero window selects the internal SRAM from the next cycle, with offset = address mod 0x2000. The remap state then stays set.
- R7: A rising edge with rst_n low clears the remap state, even if remap_i is high at that edge.
- R8: size_i is coded 0 = byte, 1 = half-word, 2 = word. Lane bit i enables byte i of the little-endian word:
  - A byte access enables lane address[1:0].
  - A half-word access enables lanes address[1:0] and address[1:0]+1.
  - A word access enables all four lanes.
- R9: The abort flag is raised, with all selects, lanes and offset at zero, in these cases:
  - size_i = 3;
  - a half-word at an odd address;
  - a word with address[1:0] ≠ 0.
- R10: An internal-region address (below 0x0040_0000) outside the zero window and both SRAM windows aborts, with the same zeroed outputs as R9.
- R11: At most one select is high, and the abort flag is high exactly when no select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_pin_i | input | 1 | Boot-select level, sampled during reset |
| remap_i | input | 1 | Single-cycle remap command |
| addr_i | input | 32 | System byte address |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| sel_int_sram_o | output | 1 | Internal 8 KB SRAM select |
| sel_ext_sram_o | output | 1 | Extended 128 KB SRAM select |
| sel_cs0_o | output | 1 | External chip select 0 |
| sel_ebi_o | output | 1 | Other external space select |
| sel_periph_o | output | 1 | Peripheral space select |
| offset_o | output | 32 | Offset within the selected region |
| lane_en_o | output | 4 | Byte-lane enables |
| abort_o | output | 1 | Access rejected |

## Verification
A wrong boot value or remap flag is visible only through the zero window. There, the select and the wrap of the offset go to the wrong memory on the very first access after reset release, or in the cycle after a remap strobe. Every other address range decodes the same either way. The bench probes the zero window at these points:
- at reset release;
- just before and just after the strobe;
- after a pin glitch in the last reset cycle;
- after a reset taken with the strobe held high.

A faulty decode or lane table shows in the same cycle as the address.

// File: rtl/bootmap_pkg.sv
`timescale 1ns/1ps
package bootmap_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic periph;
        logic ebi;
        logic cs0;
        logic ext_sram;
        logic int_sram;
    } region_sel_t;
endpackage

// File: rtl/boot_remap_state.sv
`timescale 1ns/1ps
module boot_remap_state (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_pin_i,
    input  logic remap_i,
    output logic boot_o,
    output logic remapped_o
);
    typedef struct packed {
        logic boot;
        logic remap;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.boot  = boot_pin_i;   // keeps tracking the pin until release
            st_d.remap = 1'b0;
        end else if (remap_i) begin
            st_d.remap = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign boot_o     = st_q.boot;
    assign remapped_o = st_q.remap;

    // R4: boot choice frozen while reset stays released
    a_r4_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(boot_o));
    // R6: strobe takes effect next cycle and sticks
    a_r6_remap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        remap_i |=> remapped_o);
    a_r6_remap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        remapped_o |=> remapped_o);
    // R7: reset clears remap regardless of strobe
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !remapped_o);
endmodule

// File: rtl/lane_gen.sv
`timescale 1ns/1ps
module lane_gen #(
    parameter int BUS_BYTES = 4
) (
    input  logic [$clog2(BUS_BYTES)-1:0] addr_lo_i,
    input  logic [1:0]                   size_i,
    output logic [BUS_BYTES-1:0]         lanes_o,
    output logic                         misalign_o
);
    localparam int LANE_AW  = $clog2(BUS_BYTES);
    localparam int MAX_SIZE = LANE_AW;

    always_comb begin
        int nbytes;
        int base;
        nbytes     = 1 << int'(size_i);
        base       = int'(addr_lo_i);
        misalign_o = (int'(size_i) > MAX_SIZE) || ((base % nbytes) != 0);
        for (int i = 0; i < BUS_BYTES; i++) begin
            lanes_o[i] = !misalign_o && (i >= base) && (i < base + nbytes);
        end
    end
endmodule

// File: rtl/region_decoder.sv
`timescale 1ns/1ps
module region_decoder
    import bootmap_pkg::*;
#(
    parameter int              ADDR_W        = 32,
    parameter logic [31:0]     INT_TOP       = 32'h0040_0000,
    parameter logic [31:0]     PERIPH_BASE   = 32'hFFC0_0000,
    parameter logic [31:0]     EXT_SRAM_BASE = 32'h0010_0000,
    parameter int              EXT_SRAM_AW   = 17,
    parameter logic [31:0]     INT_SRAM_BASE = 32'h0030_0000,
    parameter int              INT_SRAM_AW   = 13,
    parameter logic [31:0]     CS0_BASE      = 32'h0040_0000,
    parameter int              CS0_AW        = 21,
    parameter int              ZERO_AW       = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              boot_i,
    input  logic              remapped_i,
    output region_sel_t       sel_o,
    output logic [ADDR_W-1:0] offset_o,
    output logic              hole_o
);
    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] EXT_MASK  = (ONE << EXT_SRAM_AW) - ONE;
    localparam logic [ADDR_W-1:0] INT_MASK  = (ONE << INT_SRAM_AW) - ONE;
    localparam logic [ADDR_W-1:0] CS0_MASK  = (ONE << CS0_AW) - ONE;
    localparam logic [ADDR_W-1:0] EXT_END   = ADDR_W'(EXT_SRAM_BASE) + EXT_MASK + ONE;
    localparam logic [ADDR_W-1:0] INT_END   = ADDR_W'(INT_SRAM_BASE) + INT_MASK + ONE;
    localparam logic [ADDR_W-1:0] CS0_END   = ADDR_W'(CS0_BASE) + CS0_MASK + ONE;
    localparam logic [ADDR_W-1:0] ZERO_END  = ONE << ZERO_AW;
    localparam logic [ADDR_W-1:0] EBI_OTHER = CS0_END;

    always_comb begin
        sel_o    = '0;
        offset_o = '0;
        hole_o   = 1'b0;
        if (addr_i >= ADDR_W'(PERIPH_BASE)) begin
            sel_o.periph = 1'b1;
            offset_o     = addr_i - ADDR_W'(PERIPH_BASE);
        end else if (addr_i >= ADDR_W'(CS0_BASE) && addr_i < CS0_END) begin
            sel_o.cs0 = 1'b1;
            offset_o  = addr_i - ADDR_W'(CS0_BASE);
        end else if (addr_i >= ADDR_W'(INT_TOP)) begin
            sel_o.ebi = 1'b1;
            offset_o  = addr_i - EBI_OTHER;
        end else if (addr_i >= ADDR_W'(EXT_SRAM_BASE) && addr_i < EXT_END) begin
            sel_o.ext_sram = 1'b1;
            offset_o       = addr_i - ADDR_W'(EXT_SRAM_BASE);
        end else if (addr_i >= ADDR_W'(INT_SRAM_BASE) && addr_i < INT_END) begin
            sel_o.int_sram = 1'b1;
            offset_o       = addr_i - ADDR_W'(INT_SRAM_BASE);
        end else if (addr_i < ZERO_END) begin
            if (remapped_i) begin
                sel_o.int_sram = 1'b1;
                offset_o       = addr_i & INT_MASK;
            end else if (boot_i) begin
                sel_o.ext_sram = 1'b1;
                offset_o       = addr_i & EXT_MASK;
            end else begin
                sel_o.cs0 = 1'b1;
                offset_o  = addr_i & CS0_MASK;
            end
        end else begin
            hole_o = 1'b1;
        end
    end
endmodule

// File: rtl/boot_remap_decoder.sv
`timescale 1ns/1ps
module boot_remap_decoder
    import bootmap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_pin_i,
    input  logic                 remap_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [1:0]           size_i,
    output logic                 sel_int_sram_o,
    output logic                 sel_ext_sram_o,
    output logic                 sel_cs0_o,
    output logic                 sel_ebi_o,
    output logic                 sel_periph_o,
    output logic [ADDR_W-1:0]    offset_o,
    output logic [BUS_BYTES-1:0] lane_en_o,
    output logic                 abort_o
);
    localparam int LANE_AW = $clog2(BUS_BYTES);

    logic                 boot, remapped, hole, misalign;
    region_sel_t          raw_sel, sel;
    logic [ADDR_W-1:0]    raw_off;
    logic [BUS_BYTES-1:0] raw_lanes;

    boot_remap_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_pin_i (boot_pin_i),
        .remap_i    (remap_i),
        .boot_o     (boot),
        .remapped_o (remapped)
    );

    region_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i     (addr_i),
        .boot_i     (boot),
        .remapped_i (remapped),
        .sel_o      (raw_sel),
        .offset_o   (raw_off),
        .hole_o     (hole)
    );

    lane_gen #(.BUS_BYTES(BUS_BYTES)) u_lanes (
        .addr_lo_i  (addr_i[LANE_AW-1:0]),
        .size_i     (size_i),
        .lanes_o    (raw_lanes),
        .misalign_o (misalign)
    );

    always_comb begin
        abort_o   = misalign | hole;
        sel       = abort_o ? '0 : raw_sel;
        offset_o  = abort_o ? '0 : raw_off;
        lane_en_o = abort_o ? '0 : raw_lanes;
    end

    assign sel_int_sram_o = sel.int_sram;
    assign sel_ext_sram_o = sel.ext_sram;
    assign sel_cs0_o      = sel.cs0;
    assign sel_ebi_o      = sel.ebi;
    assign sel_periph_o   = sel.periph;

    // R11: exclusive selects, abort exactly when none
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_int_sram_o, sel_ext_sram_o, sel_cs0_o, sel_ebi_o, sel_periph_o}));
    a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (lane_en_o == '0 && offset_o == '0 &&
                     !(sel_int_sram_o | sel_ext_sram_o | sel_cs0_o | sel_ebi_o | sel_periph_o)));
    // R9: a misaligned word is always rejected
    a_r9_word_align: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd2 && addr_i[1:0] != 2'b00) |-> abort_o);
    // R8: accepted accesses enable exactly size bytes
    a_r8_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_o |-> ($countones(lane_en_o) == (1 << int'(size_i))));
    // R2: extended SRAM window independent of boot/remap
    a_r2_ext_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= 32'h0010_0000 && addr_i < 32'h0012_0000 && !abort_o) |-> sel_ext_sram_o);
    // R6: remapped zero window goes to internal SRAM
    a_r6_zero_int: assert property (@(posedge clk) disable iff (!rst_n)
        (remapped && addr_i < 32'h0010_0000 && !abort_o) |-> sel_int_sram_o);
endmodule

// File: tb/boot_remap_decoder_test.sv
`timescale 1ns/1ps
module boot_remap_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_pin = 1'b1;
    logic        remap = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = 2'd2;
    logic        s_int, s_ext, s_cs0, s_ebi, s_per, abort;
    logic [31:0] off;
    logic [3:0]  lanes;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    boot_remap_decoder uut (
        .clk(clk), .rst_n(rst_n), .boot_pin_i(boot_pin), .remap_i(remap),
        .addr_i(addr), .size_i(size),
        .sel_int_sram_o(s_int), .sel_ext_sram_o(s_ext), .sel_cs0_o(s_cs0),
        .sel_ebi_o(s_ebi), .sel_periph_o(s_per),
        .offset_o(off), .lane_en_o(lanes), .abort_o(abort)
    );

    // select vector order {periph, ebi, cs0, ext, int}
    localparam logic [4:0] S_INT = 5'b00001, S_EXT = 5'b00010, S_CS0 = 5'b00100,
                           S_EBI = 5'b01000, S_PER = 5'b10000, S_NONE = 5'b00000;

    typedef struct packed {
        logic [31:0] a;
        logic [1:0]  sz;
        logic [4:0]  sel;
        logic [31:0] off;
        logic [3:0]  ln;
        logic        ab;
    } vec_t;

    // Expected with boot value 1, before remap
    localparam vec_t TBL [17] = '{
        '{32'h0000_0004, 2'd2, S_EXT,  32'h0000_0004, 4'hF, 1'b0}, // R5 boot1 alias
        '{32'h0002_0006, 2'd1, S_EXT,  32'h0000_0006, 4'hC, 1'b0}, // R5 wrap 128K, R8
        '{32'h0010_0003, 2'd0, S_EXT,  32'h0000_0003, 4'h8, 1'b0}, // R2, R8
        '{32'h0011_FFFC, 2'd2, S_EXT,  32'h0001_FFFC, 4'hF, 1'b0}, // R2 top
        '{32'h0012_0000, 2'd2, S_NONE, 32'h0,         4'h0, 1'b1}, // R10 hole
        '{32'h0030_1FFD, 2'd0, S_INT,  32'h0000_1FFD, 4'h2, 1'b0}, // R3
        '{32'h0030_2000, 2'd2, S_NONE, 32'h0,         4'h0, 1'b1}, // R10 above int
        '{32'h0040_0000, 2'd1, S_CS0,  32'h0000_0000, 4'h3, 1'b0}, // R1 cs0
        '{32'h005F_FFFE, 2'd1, S_CS0,  32'h001F_FFFE, 4'hC, 1'b0}, // R1 cs0 top
        '{32'h0060_0000, 2'd2, S_EBI,  32'h0000_0000, 4'hF, 1'b0}, // R1 ebi
        '{32'hFFBF_FFFF, 2'd0, S_EBI,  32'hFF5F_FFFF, 4'h8, 1'b0}, // R1 ebi top
        '{32'hFFC0_0010, 2'd2, S_PER,  32'h0000_0010, 4'hF, 1'b0}, // R1 periph
        '{32'hFFFF_FFFF, 2'd0, S_PER,  32'h003F_FFFF, 4'h8, 1'b0}, // R1 periph top
        '{32'h0000_0002, 2'd2, S_NONE, 32'h0,         4'h0, 1'b1}, // R9 word
        '{32'h0010_0001, 2'd1, S_NONE, 32'h0,         4'h0, 1'b1}, // R9 half
        '{32'h0040_0000, 2'd3, S_NONE, 32'h0,         4'h0, 1'b1}, // R9 size 3
        '{32'h0020_0000, 2'd0, S_NONE, 32'h0,         4'h0, 1'b1}  // R10 gap
    };

    task automatic probe(input string tag, input logic [31:0] a, input logic [1:0] sz,
                         input logic [4:0] es, input logic [31:0] eo,
                         input logic [3:0] el, input logic ea);
        logic [4:0] got;
        addr = a;
        size = sz;
        #1;
        got = {s_per, s_ebi, s_cs0, s_ext, s_int};
        n_checks++;
        if (got !== es || off !== eo || lanes !== el || abort !== ea) begin
            n_fail++;
            $display("FAIL %s addr=%h: sel=%b off=%h lanes=%h abort=%b expected sel=%b off=%h lanes=%h abort=%b",
                     tag, a, got, off, lanes, abort, es, eo, el, ea);
        end
    endtask

    task automatic reset_with(input logic pin, input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        boot_pin = pin;
        repeat (cycles) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_remap();
        remap = 1'b1;
        @(negedge clk);
        remap = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        reset_with(1'b1, 12);
        // reset state: boot 1, no remap (R4, R5, R7)
        probe("R7 reset state zero window", 32'h0000_0000, 2'd2, S_EXT, 32'h0, 4'hF, 1'b0);

        for (int i = 0; i < 17; i++) begin
            probe($sformatf("table %0d", i), TBL[i].a, TBL[i].sz, TBL[i].sel,
                  TBL[i].off, TBL[i].ln, TBL[i].ab);
        end

        // R6: strobe visible only from the next cycle
        @(negedge clk);
        remap = 1'b1;
        probe("R6 before strobe edge", 32'h0000_0010, 2'd2, S_EXT, 32'h10, 4'hF, 1'b0);
        @(negedge clk);
        remap = 1'b0;
        probe("R6 after strobe", 32'h0000_0010, 2'd2, S_INT, 32'h10, 4'hF, 1'b0);
        probe("R6 wrap 8K", 32'h000F_E004, 2'd2, S_INT, 32'h4, 4'hF, 1'b0);
        probe("R2 after remap", 32'h0010_0000, 2'd2, S_EXT, 32'h0, 4'hF, 1'b0);
        probe("R3 after remap", 32'h0030_0008, 2'd1, S_INT, 32'h8, 4'h3, 1'b0);
        repeat (5) @(negedge clk);
        probe("R6 sticky", 32'h0000_0020, 2'd0, S_INT, 32'h20, 4'h1, 1'b0);

        // R4: pin drops only at the last reset edge -> boot 0
        @(negedge clk);
        rst_n = 1'b0;
        boot_pin = 1'b1;
        repeat (6) @(negedge clk);
        boot_pin = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe("R4 last sample wins", 32'h0000_0100, 2'd2, S_CS0, 32'h100, 4'hF, 1'b0);
        probe("R5 boot0 top", 32'h000F_FFFF, 2'd0, S_CS0, 32'h000F_FFFF, 4'h8, 1'b0);
        // R4: pin change after release ignored
        boot_pin = 1'b1;
        repeat (3) @(negedge clk);
        probe("R4 pin ignored after release", 32'h0000_0100, 2'd2, S_CS0, 32'h100, 4'hF, 1'b0);
        pulse_remap();
        probe("R6 remap from boot0", 32'h0000_2004, 2'd2, S_INT, 32'h4, 4'hF, 1'b0);

        // R7: reset with strobe held clears remap
        @(negedge clk);
        rst_n = 1'b0;
        remap = 1'b1;
        boot_pin = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        remap = 1'b0;
        probe("R7 remap cleared", 32'h0000_0040, 2'd2, S_CS0, 32'h40, 4'hF, 1'b0);
        probe("R11 hole quiet", 32'h003F_FFF0, 2'd2, S_NONE, 32'h0, 4'h0, 1'b1);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule